// File: doc/BRIEF.md
# Mark-Density Loss-of-Signal Detector

This block watches the bit stream recovered from one receive port and keeps a loss-of-signal flag. One bit is accepted per recovered-clock cycle. A long unbroken run of spaces (a space is a 0 bit and a mark is a 1 bit) raises the flag. The flag drops again only when the recent stream shows enough marks and has no long gap between them. Every accepted bit is also copied to a registered output, so received marks still reach downstream logic while the flag is high.

The input side is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a bit moves whenever `in_valid` is high on a clock edge. The output stream has no ready input. `out_valid` pulses for one cycle per accepted bit and must be consumed in that cycle. The flag is a plain level driven straight from a register. Reset is synchronous and active high.

Top module: `los_detector`

## Requirements
- R1: While reset is held, and right after it, `los` is 1 and `out_valid` is 0.
- R2: `los` becomes 1 at the clock edge that accepts the 175th consecutive 0 bit (LOS_RUN, default 175).
- R3: A 1 bit restarts the space count. After a 1, a run of 174 zeros leaves a low `los` low.
- R4: While `los` is 1, it becomes 0 at the edge that accepts a bit after which the newest 32 accepted bits hold at least 4 ones and no run of more than 15 zeros. The history before the first bit after reset counts as zeros.
- R5: While `los` is 1, it stays 1 as long as the newest 32 accepted bits hold fewer than 4 ones.
- R6: While `los` is 1, it stays 1 as long as the newest 32 accepted bits contain a run of 16 or more zeros, however many ones they hold.
- R7: `los` changes only on edges where a bit is accepted. Cycles with `in_valid` low leave it unchanged.
- R8: Each accepted bit appears on `out_bit` with `out_valid` high one cycle later, whatever the state of `los`. `out_valid` is 0 in cycles after no bit was accepted.
- R9: `in_ready` is always 1, so the input stream never sees back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received bit is present this cycle |
| in_ready | output | 1 | Always high; bits are accepted every cycle |
| in_bit | input | 1 | Received bit, 1 = mark, 0 = space |
| out_valid | output | 1 | Registered copy of an accepted bit is present |
| out_bit | output | 1 | Registered copy of the accepted bit |
| los | output | 1 | Loss-of-signal flag, registered |

## Verification
The flag and the copied bit are both due one clock edge after the bit is accepted, with no other register in the path. The bench therefore drives each bit on a falling edge and compares both results at the next falling edge. A model built from the requirements follows the last 32 bits and the current zero run, and the bench compares the flag with that model after every bit and every idle cycle. A sweep of mark spacings from 1 to 20 moves the window from dense enough, through too few marks, to too long a gap. Directed runs of exactly 174 and 175 zeros, and a window whose longest gap shrinks from 16 to 15 zeros, pin down where the flag changes.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned DEF_LOS_RUN   = 175;
  localparam int unsigned DEF_WIN       = 32;
  localparam int unsigned DEF_MIN_MARKS = 4;
  localparam int unsigned DEF_MAX_ZRUN  = 15;

  typedef struct packed {
    logic enough_marks;
    logic gaps_short;
  } density_t;
endpackage

// File: rtl/los_space_run.sv
module los_space_run #(
  parameter int unsigned RUN_LIMIT = 175
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_val,
  output logic run_hit
);
  localparam int unsigned RW = $clog2(RUN_LIMIT + 1);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (bit_valid) begin
      if (bit_val)                    run_d = '0;
      else if (run_q != RW'(RUN_LIMIT)) run_d = run_q + RW'(1);
    end
  end

  assign run_hit = bit_valid && !bit_val && (run_d == RW'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_d;
  end
endmodule

// File: rtl/los_density_window.sv
module los_density_window
  import los_pkg::*;
#(
  parameter int unsigned WIN       = 32,
  parameter int unsigned MIN_MARKS = 4,
  parameter int unsigned MAX_ZRUN  = 15
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_valid,
  input  logic     bit_val,
  output density_t dens_next
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [WIN-1:0] win_q, win_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  run_v, longest_v;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (bit_valid) begin
      win_d = {win_q[WIN-2:0], bit_val};
      cnt_d = cnt_q + CW'(bit_val) - CW'(win_q[WIN-1]);
    end
  end

  always_comb begin
    run_v     = '0;
    longest_v = '0;
    for (int i = 0; i < int'(WIN); i++) begin
      if (win_d[i]) begin
        run_v = '0;
      end else begin
        run_v = run_v + CW'(1);
        if (run_v > longest_v) longest_v = run_v;
      end
    end
  end

  assign dens_next.enough_marks = (cnt_d >= CW'(MIN_MARKS));
  assign dens_next.gaps_short   = (longest_v <= CW'(MAX_ZRUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int unsigned LOS_RUN   = DEF_LOS_RUN,
  parameter int unsigned WIN       = DEF_WIN,
  parameter int unsigned MIN_MARKS = DEF_MIN_MARKS,
  parameter int unsigned MAX_ZRUN  = DEF_MAX_ZRUN
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic los
);
  logic     run_hit;
  density_t dens;
  logic     los_q, ov_q, ob_q;

  assign in_ready = 1'b1;

  los_space_run #(.RUN_LIMIT(LOS_RUN)) u_run (
    .clk(clk), .rst(rst), .bit_valid(in_valid), .bit_val(in_bit),
    .run_hit(run_hit)
  );

  los_density_window #(.WIN(WIN), .MIN_MARKS(MIN_MARKS), .MAX_ZRUN(MAX_ZRUN)) u_win (
    .clk(clk), .rst(rst), .bit_valid(in_valid), .bit_val(in_bit),
    .dens_next(dens)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      los_q <= 1'b1;
      ov_q  <= 1'b0;
      ob_q  <= 1'b0;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        ob_q <= in_bit;
        if (run_hit)                                    los_q <= 1'b1;
        else if (dens.enough_marks && dens.gaps_short)  los_q <= 1'b0;
      end
    end
  end

  assign los       = los_q;
  assign out_valid = ov_q;
  assign out_bit   = ob_q;
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
  parameter int unsigned LOS_RUN  = 175,
  parameter int unsigned MAX_ZRUN = 15
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_bit,
  input logic out_valid,
  input logic out_bit,
  input logic los
);
  localparam int unsigned ZW = $clog2(LOS_RUN + 1);
  logic [ZW-1:0] zc;

  always_ff @(posedge clk) begin
    if (rst) zc <= '0;
    else if (in_valid) begin
      if (in_bit)                  zc <= '0;
      else if (zc != ZW'(LOS_RUN)) zc <= zc + ZW'(1);
    end
  end

  p_rise_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> (zc == ZW'(LOS_RUN)));

  p_clear_short_gap_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(los) |-> (zc <= ZW'(MAX_ZRUN)));

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(los));

  p_pass_valid_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_pass_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_pass_data_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_bit == $past(in_bit)));
endmodule

bind los_detector los_detector_chk #(.LOS_RUN(LOS_RUN), .MAX_ZRUN(MAX_ZRUN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
  .out_valid(out_valid), .out_bit(out_bit), .los(los)
);

// File: tb/los_detector_tb.sv
`timescale 1ns/1ps
module los_detector_tb;
  logic clk = 1'b0;
  logic rst, in_valid, in_bit;
  logic in_ready, out_valid, out_bit, los;
  int checks = 0;
  int errors = 0;

  logic [31:0] hist = '0;
  int mrun = 0;
  logic mlos = 1'b1;

  always #2.5 clk = ~clk;

  los_detector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit), .los(los)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_bit(input logic b);
    int marks, run, longest;
    hist = {hist[30:0], b};
    if (b) mrun = 0;
    else if (mrun < 175) mrun++;
    marks = $countones(hist);
    run = 0; longest = 0;
    for (int i = 0; i < 32; i++) begin
      if (hist[i]) run = 0;
      else begin
        run++;
        if (run > longest) longest = run;
      end
    end
    if (mrun >= 175) mlos = 1'b1;
    else if (marks >= 4 && longest <= 15) mlos = 1'b0;
  endtask

  task automatic send_bit(input logic b, input string tag);
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model_bit(b);
    chk(los == mlos, tag, los, mlos);
    chk(out_valid == 1'b1, "R8 valid", out_valid, 1);
    chk(out_bit == b, "R8 data", out_bit, b);
    chk(in_ready == 1'b1, "R9", in_ready, 1);
  endtask

  task automatic send_zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'b0, tag);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(los == mlos, "R7", los, mlos);
      chk(out_valid == 1'b0, "R8 idle", out_valid, 0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(los == 1'b1, "R1 los", los, 1);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    rst = 1'b0;
    idle(2);
    chk(los == 1'b1, "R1 after", los, 1);

    for (int k = 0; k < 8; k++) begin
      send_zeros(3, "R4");
      send_bit(1'b1, "R4");
    end
    chk(los == 1'b0, "R4 dense", los, 0);
    idle(3);

    send_zeros(174, "R3");
    chk(los == 1'b0, "R3 174", los, 0);
    send_bit(1'b1, "R3");
    send_zeros(174, "R3");
    chk(los == 1'b0, "R3 restart", los, 0);
    send_bit(1'b0, "R2");
    chk(los == 1'b1, "R2 175", los, 1);
    idle(4);

    for (int k = 0; k < 4; k++) begin
      send_zeros(10, "R5");
      send_bit(1'b1, "R5");
    end
    chk(los == 1'b1, "R5 sparse", los, 1);

    send_zeros(175, "R6");
    for (int k = 0; k < 4; k++) send_bit(1'b1, "R6");
    send_zeros(12, "R6");
    chk(los == 1'b1, "R6 gap16", los, 1);
    send_bit(1'b0, "R4");
    chk(los == 1'b0, "R4 gap15", los, 0);

    for (int s = 1; s <= 20; s++) begin
      send_zeros(175, "R2");
      for (int k = 0; k < 64; k++)
        send_bit(((k % s) == (s - 1)) ? 1'b1 : 1'b0, "R4 R5 R6 sweep");
      idle(2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule